// File: doc/BRIEF.md
# Aspect-Preserving Upscaler Window Calculator

This block works out the output window for a display upscaler when a smaller source image has to fill a larger visible display area. It takes the source width and height, the visible width and height, and a few configuration flags. It finds the largest window that keeps the source aspect ratio and fits the allowed area, then centres that window. The result is three packed 32-bit register words: control, window position and window size.

The block supports two scaler flavours. A per-pipe scaler limits the upscale ratio on each axis. A simpler panel fitter may use the whole visible area. All divisions share one restoring divider that produces one quotient bit per clock, so a request finishes in a bounded number of cycles. A disable request sends the two words that switch the scaler off. Source sizes of zero are rejected. A source that already matches the visible size needs no scaling.

Top module: `scaler_window_calc`

## Requirements
- R1: If the source width and height are both equal to the visible size, no word is emitted, `done_o` pulses and `bypass_o` goes high. `bypass_o` stays high until the next request.
- R2: The fit is computed as follows, with every division truncating. First, trial height = (max_w·src_h)/src_w. If trial height ≤ max_h, the window is max_w × trial height. Otherwise the height is max_h and the width is min(max_w, (max_h·src_w)/src_h).
- R3: In pipe-scaler mode (`pipe_mode_i`=1), max_w = min(vis_w, (src_w·299)/100) and max_h = min(vis_h, (src_h·R)/100). R is 199 when `has_second_i`=0 and src_w > 2048; otherwise R is 299.
- R4: In panel-fitter mode (`pipe_mode_i`=0), max_w and max_h are the visible width and height.
- R5: The position word is ((vis_w−width)/2) in bits 31:16 and ((vis_h−height)/2) in bits 15:0. The size word is width in bits 31:16 and height in bits 15:0.
- R6: The pipe-scaler control word has bit 31 set. Bit 28 is also set when `has_second_i`=1. All other bits are zero.
- R7: The panel-fitter control word has bits 31 and 23 set. When `pipe_sel_en_i`=1, bits 30:29 hold `pipe_idx_i`; otherwise they are zero. All other bits are zero.
- R8: Words leave on consecutive cycles in this order: control (kind 0), position (kind 1), size (kind 2). `done_o` pulses in the same cycle as the size word.
- R9: The emitted width never exceeds vis_w and the emitted height never exceeds vis_h.
- R10: A disable request (`off_i` while idle, with `start_i` low) emits a control word of zero (kind 0), then a size word of zero (kind 2). `done_o` pulses with the size word.
- R11: A source width or height of zero sets `err_o`, emits no word and pulses `done_o`. `err_o` stays high until the next request.
- R12: A request completes, with `done_o`, within 4·(2·DIM_W+4)+10 cycles of the cycle in which it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a computation; sampled only while idle |
| off_i | input | 1 | Disable request; sampled while idle when start_i is low |
| pipe_mode_i | input | 1 | 1 = pipe scaler, 0 = panel fitter |
| has_second_i | input | 1 | This instance has a second scaler |
| pipe_sel_en_i | input | 1 | Panel fitter supports pipe selection |
| pipe_idx_i | input | 2 | Pipe index for the panel fitter control word |
| src_w_i | input | DIM_W | Source width |
| src_h_i | input | DIM_W | Source height |
| vis_w_i | input | DIM_W | Visible width |
| vis_h_i | input | DIM_W | Visible height |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle pulse when a request ends |
| bypass_o | output | 1 | Last request needed no scaling |
| err_o | output | 1 | Last request had a zero source dimension |
| word_valid_o | output | 1 | word_o and word_kind_o are valid |
| word_kind_o | output | 2 | 0 control, 1 position, 2 size |
| word_o | output | 2·DIM_W | Packed register word |

## Verification
The bench uses the default DIM_W of 16. That gives 32-bit words, 32-bit products and a 32-step divider, so sources on either side of the 2048-pixel width threshold can be tested. Sizes up to 8000 pixels let the 2.99x and 1.99x limits take effect. The vectors cover cases where the trial height fits, where the alternate width is chosen, and where the narrowed vertical limit binds. The same source is run with and without a second scaler to show the difference.

// File: rtl/scw_pkg.sv
package scw_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LIM_W,
    ST_LIM_H,
    ST_TRIAL,
    ST_ALT_W,
    ST_EM_CTRL,
    ST_EM_POS,
    ST_EM_SIZE,
    ST_OFF_CTRL,
    ST_OFF_SIZE
  } calc_state_t;

  typedef enum logic [1:0] {
    KIND_CTRL = 2'd0,
    KIND_POS  = 2'd1,
    KIND_SIZE = 2'd2
  } word_kind_t;

  localparam int unsigned RATIO_FULL   = 299;
  localparam int unsigned RATIO_NARROW = 199;
  localparam int unsigned RATIO_DEN    = 100;
  localparam int unsigned WIDE_SRC     = 2048;

  localparam int unsigned BIT_ENABLE   = 31;
  localparam int unsigned BIT_EXT_MODE = 28;
  localparam int unsigned BIT_FILT_MED = 23;
  localparam int unsigned PSEL_LSB     = 29;

endpackage

// File: rtl/scw_div.sv
module scw_div #(
  parameter int unsigned NUM_W = 32,
  parameter int unsigned DEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [NUM_W-1:0] quot_o
);
  localparam int unsigned CNT_W = $clog2(NUM_W + 1);
  localparam int unsigned CHK_W = NUM_W + DEN_W;

  logic [NUM_W-1:0] acc_q, acc_n, num_q, num_n;
  logic [DEN_W-1:0] rem_q, rem_n, den_q, den_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             busy_q, busy_n, done_q, done_n;
  logic [DEN_W:0]   shifted, diff;
  logic             fits;

  assign shifted = {rem_q, acc_q[NUM_W-1]};
  assign diff    = shifted - {1'b0, den_q};
  assign fits    = shifted >= {1'b0, den_q};

  always_comb begin
    acc_n  = acc_q;
    num_n  = num_q;
    rem_n  = rem_q;
    den_n  = den_q;
    cnt_n  = cnt_q;
    busy_n = busy_q;
    done_n = 1'b0;
    if (start_i && !busy_q) begin
      acc_n  = num_i;
      num_n  = num_i;
      rem_n  = '0;
      den_n  = den_i;
      cnt_n  = CNT_W'(NUM_W);
      busy_n = 1'b1;
    end else if (busy_q) begin
      acc_n = {acc_q[NUM_W-2:0], fits};
      rem_n = fits ? diff[DEN_W-1:0] : shifted[DEN_W-1:0];
      cnt_n = cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      num_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      acc_q  <= acc_n;
      num_q  <= num_n;
      rem_q  <= rem_n;
      den_q  <= den_n;
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
      done_q <= done_n;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quot_o = acc_q;

  // R2
  div_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (CHK_W'(acc_q) * CHK_W'(den_q) + CHK_W'(rem_q) == CHK_W'(num_q))
               && (rem_q < den_q));

  // R12
  div_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/scw_opsel.sv
module scw_opsel
  import scw_pkg::*;
#(
  parameter int unsigned DIM_W = 16,
  localparam int unsigned NUM_W = 2 * DIM_W
) (
  input  calc_state_t      state_i,
  input  logic             narrow_i,
  input  logic [DIM_W-1:0] src_w_i,
  input  logic [DIM_W-1:0] src_h_i,
  input  logic [DIM_W-1:0] max_w_i,
  input  logic [DIM_W-1:0] max_h_i,
  output logic [NUM_W-1:0] num_o,
  output logic [DIM_W-1:0] den_o
);
  logic [NUM_W-1:0] ratio_v;

  assign ratio_v = narrow_i ? NUM_W'(RATIO_NARROW) : NUM_W'(RATIO_FULL);

  always_comb begin
    num_o = '0;
    den_o = DIM_W'(1);
    unique case (state_i)
      ST_LIM_W: begin
        num_o = NUM_W'(src_w_i) * NUM_W'(RATIO_FULL);
        den_o = DIM_W'(RATIO_DEN);
      end
      ST_LIM_H: begin
        num_o = NUM_W'(src_h_i) * ratio_v;
        den_o = DIM_W'(RATIO_DEN);
      end
      ST_TRIAL: begin
        num_o = NUM_W'(max_w_i) * NUM_W'(src_h_i);
        den_o = src_w_i;
      end
      ST_ALT_W: begin
        num_o = NUM_W'(max_h_i) * NUM_W'(src_w_i);
        den_o = src_h_i;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/scw_pack.sv
module scw_pack
  import scw_pkg::*;
#(
  parameter int unsigned DIM_W = 16,
  localparam int unsigned WORD_W = 2 * DIM_W
) (
  input  logic              pipe_mode_i,
  input  logic              has_second_i,
  input  logic              pipe_sel_en_i,
  input  logic [1:0]        pipe_idx_i,
  input  logic [DIM_W-1:0]  vis_w_i,
  input  logic [DIM_W-1:0]  vis_h_i,
  input  logic [DIM_W-1:0]  win_w_i,
  input  logic [DIM_W-1:0]  win_h_i,
  output logic [WORD_W-1:0] ctrl_o,
  output logic [WORD_W-1:0] pos_o,
  output logic [WORD_W-1:0] size_o
);
  logic [DIM_W-1:0] off_x, off_y;

  always_comb begin
    ctrl_o = '0;
    ctrl_o[BIT_ENABLE] = 1'b1;
    if (pipe_mode_i) begin
      ctrl_o[BIT_EXT_MODE] = has_second_i;
    end else begin
      ctrl_o[BIT_FILT_MED] = 1'b1;
      if (pipe_sel_en_i) ctrl_o[PSEL_LSB +: 2] = pipe_idx_i;
    end
  end

  assign off_x  = (vis_w_i - win_w_i) >> 1;
  assign off_y  = (vis_h_i - win_h_i) >> 1;
  assign pos_o  = {off_x, off_y};
  assign size_o = {win_w_i, win_h_i};

endmodule

// File: rtl/scaler_window_calc.sv
module scaler_window_calc
  import scw_pkg::*;
#(
  parameter int unsigned DIM_W = 16,
  localparam int unsigned WORD_W = 2 * DIM_W,
  localparam int unsigned NUM_W  = 2 * DIM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              off_i,
  input  logic              pipe_mode_i,
  input  logic              has_second_i,
  input  logic              pipe_sel_en_i,
  input  logic [1:0]        pipe_idx_i,
  input  logic [DIM_W-1:0]  src_w_i,
  input  logic [DIM_W-1:0]  src_h_i,
  input  logic [DIM_W-1:0]  vis_w_i,
  input  logic [DIM_W-1:0]  vis_h_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              bypass_o,
  output logic              err_o,
  output logic              word_valid_o,
  output logic [1:0]        word_kind_o,
  output logic [WORD_W-1:0] word_o
);
  calc_state_t      state_q, state_n;
  logic             pipe_q, pipe_n, has2_q, has2_n, psel_q, psel_n;
  logic [1:0]       idx_q, idx_n;
  logic [DIM_W-1:0] sw_q, sw_n, sh_q, sh_n, vw_q, vw_n, vh_q, vh_n;
  logic [DIM_W-1:0] mw_q, mw_n, mh_q, mh_n, ww_q, ww_n, wh_q, wh_n;
  logic             launched_q, launched_n;
  logic             done_q, done_n, byp_q, byp_n, err_q, err_n, wv_q, wv_n;
  logic [1:0]       kind_q, kind_n;
  logic [WORD_W-1:0] word_q, word_n;

  logic             div_start, div_busy, div_done, narrow;
  logic [NUM_W-1:0] div_num, div_q;
  logic [DIM_W-1:0] div_den;
  logic [WORD_W-1:0] ctrl_w, pos_w, size_w;
  logic             in_div;

  assign narrow = !has2_q && (sw_q > DIM_W'(WIDE_SRC));
  assign in_div = (state_q == ST_LIM_W) || (state_q == ST_LIM_H) ||
                  (state_q == ST_TRIAL) || (state_q == ST_ALT_W);

  scw_opsel #(.DIM_W(DIM_W)) u_opsel (
    .state_i (state_q), .narrow_i(narrow),
    .src_w_i (sw_q),    .src_h_i (sh_q),
    .max_w_i (mw_q),    .max_h_i (mh_q),
    .num_o   (div_num), .den_o   (div_den)
  );

  scw_div #(.NUM_W(NUM_W), .DEN_W(DIM_W)) u_div (
    .clk    (clk),      .rst_n (rst_n),
    .start_i(div_start), .num_i(div_num), .den_i(div_den),
    .busy_o (div_busy), .done_o(div_done), .quot_o(div_q)
  );

  scw_pack #(.DIM_W(DIM_W)) u_pack (
    .pipe_mode_i  (pipe_q), .has_second_i(has2_q),
    .pipe_sel_en_i(psel_q), .pipe_idx_i  (idx_q),
    .vis_w_i      (vw_q),   .vis_h_i     (vh_q),
    .win_w_i      (ww_q),   .win_h_i     (wh_q),
    .ctrl_o       (ctrl_w), .pos_o       (pos_w), .size_o(size_w)
  );

  always_comb begin
    state_n = state_q;
    pipe_n = pipe_q; has2_n = has2_q; psel_n = psel_q; idx_n = idx_q;
    sw_n = sw_q; sh_n = sh_q; vw_n = vw_q; vh_n = vh_q;
    mw_n = mw_q; mh_n = mh_q; ww_n = ww_q; wh_n = wh_q;
    launched_n = launched_q;
    byp_n = byp_q; err_n = err_q;
    done_n = 1'b0; wv_n = 1'b0; kind_n = kind_q; word_n = word_q;
    div_start = 1'b0;

    if (in_div) begin
      if (!launched_q && !div_busy) begin
        div_start  = 1'b1;
        launched_n = 1'b1;
      end
    end

    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          pipe_n = pipe_mode_i; has2_n = has_second_i;
          psel_n = pipe_sel_en_i; idx_n = pipe_idx_i;
          sw_n = src_w_i; sh_n = src_h_i; vw_n = vis_w_i; vh_n = vis_h_i;
          mw_n = vis_w_i; mh_n = vis_h_i;
          byp_n = 1'b0; err_n = 1'b0;
          if (src_w_i == '0 || src_h_i == '0) begin
            err_n = 1'b1; done_n = 1'b1;
          end else if (src_w_i == vis_w_i && src_h_i == vis_h_i) begin
            byp_n = 1'b1; done_n = 1'b1;
          end else begin
            state_n = pipe_mode_i ? ST_LIM_W : ST_TRIAL;
          end
        end else if (off_i) begin
          byp_n = 1'b0; err_n = 1'b0;
          state_n = ST_OFF_CTRL;
        end
      end
      ST_LIM_W: if (launched_q && div_done) begin
        launched_n = 1'b0;
        mw_n = (div_q < NUM_W'(vw_q)) ? div_q[DIM_W-1:0] : vw_q;
        state_n = ST_LIM_H;
      end
      ST_LIM_H: if (launched_q && div_done) begin
        launched_n = 1'b0;
        mh_n = (div_q < NUM_W'(vh_q)) ? div_q[DIM_W-1:0] : vh_q;
        state_n = ST_TRIAL;
      end
      ST_TRIAL: if (launched_q && div_done) begin
        launched_n = 1'b0;
        if (div_q <= NUM_W'(mh_q)) begin
          ww_n = mw_q; wh_n = div_q[DIM_W-1:0];
          state_n = ST_EM_CTRL;
        end else begin
          wh_n = mh_q;
          state_n = ST_ALT_W;
        end
      end
      ST_ALT_W: if (launched_q && div_done) begin
        launched_n = 1'b0;
        ww_n = (div_q < NUM_W'(mw_q)) ? div_q[DIM_W-1:0] : mw_q;
        state_n = ST_EM_CTRL;
      end
      ST_EM_CTRL: begin
        wv_n = 1'b1; kind_n = KIND_CTRL; word_n = ctrl_w; state_n = ST_EM_POS;
      end
      ST_EM_POS: begin
        wv_n = 1'b1; kind_n = KIND_POS; word_n = pos_w; state_n = ST_EM_SIZE;
      end
      ST_EM_SIZE: begin
        wv_n = 1'b1; kind_n = KIND_SIZE; word_n = size_w;
        done_n = 1'b1; state_n = ST_IDLE;
      end
      ST_OFF_CTRL: begin
        wv_n = 1'b1; kind_n = KIND_CTRL; word_n = '0; state_n = ST_OFF_SIZE;
      end
      ST_OFF_SIZE: begin
        wv_n = 1'b1; kind_n = KIND_SIZE; word_n = '0;
        done_n = 1'b1; state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pipe_q <= 1'b0; has2_q <= 1'b0; psel_q <= 1'b0; idx_q <= '0;
      sw_q <= '0; sh_q <= '0; vw_q <= '0; vh_q <= '0;
      mw_q <= '0; mh_q <= '0; ww_q <= '0; wh_q <= '0;
      launched_q <= 1'b0;
      done_q <= 1'b0; byp_q <= 1'b0; err_q <= 1'b0; wv_q <= 1'b0;
      kind_q <= '0; word_q <= '0;
    end else begin
      state_q <= state_n;
      pipe_q <= pipe_n; has2_q <= has2_n; psel_q <= psel_n; idx_q <= idx_n;
      sw_q <= sw_n; sh_q <= sh_n; vw_q <= vw_n; vh_q <= vh_n;
      mw_q <= mw_n; mh_q <= mh_n; ww_q <= ww_n; wh_q <= wh_n;
      launched_q <= launched_n;
      done_q <= done_n; byp_q <= byp_n; err_q <= err_n; wv_q <= wv_n;
      kind_q <= kind_n; word_q <= word_n;
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign bypass_o     = byp_q;
  assign err_o        = err_q;
  assign word_valid_o = wv_q;
  assign word_kind_o  = kind_q;
  assign word_o       = word_q;

  // R8
  pos_after_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wv_q && kind_q == KIND_POS) |-> $past(wv_q && kind_q == KIND_CTRL));

  // R8
  size_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wv_q && kind_q == KIND_SIZE) |-> (done_q && $past(wv_q)));

  // R9
  win_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wv_q && kind_q == KIND_SIZE && word_q != '0) |->
      (word_q[WORD_W-1:DIM_W] <= vw_q && word_q[DIM_W-1:0] <= vh_q));

  // R10
  off_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wv_q && kind_q == KIND_CTRL && word_q == '0) |=>
      (wv_q && kind_q == KIND_SIZE && word_q == '0));

  // R11
  err_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !wv_q);

  // R1
  bypass_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byp_q |-> !wv_q);

  // R2
  nonzero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_start |-> (div_den != '0));

endmodule

// File: tb/scaler_window_calc_bench.sv
module scaler_window_calc_bench;
  localparam int DIM_W = 16;
  localparam int WORD_W = 2 * DIM_W;
  localparam int BOUND = 4 * (2 * DIM_W + 4) + 10;

  typedef struct packed {
    logic        pipe;
    logic        has2;
    logic        psel;
    logic [1:0]  idx;
    logic [15:0] sw;
    logic [15:0] sh;
    logic [15:0] vw;
    logic [15:0] vh;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b1, 1'b0, 2'd0, 16'd1280, 16'd720,  16'd1920, 16'd1080},
    '{1'b1, 1'b1, 1'b0, 2'd0, 16'd640,  16'd480,  16'd1920, 16'd1080},
    '{1'b1, 1'b0, 1'b0, 2'd0, 16'd2560, 16'd1000, 16'd3840, 16'd2160},
    '{1'b1, 1'b0, 1'b0, 2'd0, 16'd2100, 16'd500,  16'd8000, 16'd4000},
    '{1'b1, 1'b1, 1'b0, 2'd0, 16'd2100, 16'd500,  16'd8000, 16'd4000},
    '{1'b0, 1'b0, 1'b1, 2'd2, 16'd800,  16'd600,  16'd1366, 16'd768},
    '{1'b0, 1'b0, 1'b0, 2'd1, 16'd1024, 16'd768,  16'd1920, 16'd1200},
    '{1'b0, 1'b1, 1'b1, 2'd1, 16'd100,  16'd600,  16'd8000, 16'd700}
  };

  logic clk, rst_n;
  logic start_i, off_i, pipe_mode_i, has_second_i, pipe_sel_en_i;
  logic [1:0] pipe_idx_i;
  logic [DIM_W-1:0] src_w_i, src_h_i, vis_w_i, vis_h_i;
  logic busy_o, done_o, bypass_o, err_o, word_valid_o;
  logic [1:0] word_kind_o;
  logic [WORD_W-1:0] word_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [WORD_W-1:0] got_w [4];
  logic [1:0]        got_k [4];
  int                got_n;
  int                got_cyc;
  bit                got_done;

  scaler_window_calc #(.DIM_W(DIM_W)) u_scaler_window_calc (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic void model(input vec_t v, output longint ctrl, output longint pos,
                                output longint size);
    longint mw, mh, tw, th, rat;
    if (v.pipe) begin
      rat = (!v.has2 && v.sw > 2048) ? 199 : 299;
      mw = (longint'(v.sw) * 299) / 100;
      mh = (longint'(v.sh) * rat) / 100;
      if (mw > v.vw) mw = v.vw;
      if (mh > v.vh) mh = v.vh;
      ctrl = (64'd1 << 31) | (v.has2 ? (64'd1 << 28) : 64'd0);
    end else begin
      mw = v.vw;
      mh = v.vh;
      ctrl = (64'd1 << 31) | (64'd1 << 23) | (v.psel ? (longint'(v.idx) << 29) : 64'd0);
    end
    th = (mw * v.sh) / v.sw;
    if (th <= mh) begin
      tw = mw;
    end else begin
      th = mh;
      tw = (mh * v.sw) / v.sh;
      if (tw > mw) tw = mw;
    end
    pos  = (((longint'(v.vw) - tw) / 2) << 16) | ((longint'(v.vh) - th) / 2);
    size = (tw << 16) | th;
  endfunction

  task automatic run_req(input bit is_off, input vec_t v);
    @(negedge clk);
    pipe_mode_i = v.pipe; has_second_i = v.has2; pipe_sel_en_i = v.psel;
    pipe_idx_i = v.idx; src_w_i = v.sw; src_h_i = v.sh; vis_w_i = v.vw; vis_h_i = v.vh;
    start_i = !is_off; off_i = is_off;
    @(negedge clk);
    start_i = 1'b0; off_i = 1'b0;
    got_n = 0; got_cyc = 0; got_done = 1'b0;
    for (int c = 1; c <= BOUND + 20; c++) begin
      if (word_valid_o && got_n < 4) begin
        got_w[got_n] = word_o;
        got_k[got_n] = word_kind_o;
        got_n++;
      end
      if (done_o) begin
        got_done = 1'b1;
        got_cyc = c;
        break;
      end
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    vec_t tv;
    longint ec, ep, es;
    rst_n = 1'b0; start_i = 1'b0; off_i = 1'b0;
    pipe_mode_i = 1'b0; has_second_i = 1'b0; pipe_sel_en_i = 1'b0; pipe_idx_i = '0;
    src_w_i = '0; src_h_i = '0; vis_w_i = '0; vis_h_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && !word_valid_o && !bypass_o && !err_o, "reset R8",
        {busy_o, done_o, word_valid_o, bypass_o, err_o}, 0);

    for (int i = 0; i < NVEC; i++) begin
      model(VECS[i], ec, ep, es);
      run_req(1'b0, VECS[i]);
      chk(got_done && got_cyc <= BOUND, "R12 latency", got_cyc, BOUND);
      chk(got_n == 3, "R8 word count", got_n, 3);
      chk(got_k[0] == 2'd0 && got_k[1] == 2'd1 && got_k[2] == 2'd2, "R8 order",
          {got_k[0], got_k[1], got_k[2]}, 6'b000110);
      chk(got_w[0] == ec, VECS[i].pipe ? "R6 pipe ctrl" : "R7 fitter ctrl", got_w[0], ec);
      chk(got_w[1] == ep, "R5 position", got_w[1], ep);
      chk(got_w[2] == es, VECS[i].pipe ? "R3 R2 size" : "R4 R2 size", got_w[2], es);
      chk(got_w[2][31:16] <= VECS[i].vw && got_w[2][15:0] <= VECS[i].vh, "R9 within visible",
          got_w[2], {VECS[i].vw, VECS[i].vh});
      chk(!bypass_o && !err_o, "R1 R11 flags low", {bypass_o, err_o}, 0);
    end

    // R3: narrowed vertical limit gives 4179x995, full limit 6279x1495
    model(VECS[3], ec, ep, es);
    chk(es == ((64'd4179 << 16) | 64'd995), "R3 narrow model", es, (64'd4179 << 16) | 64'd995);

    // R1 bypass
    tv = '{1'b1, 1'b1, 1'b0, 2'd0, 16'd1920, 16'd1080, 16'd1920, 16'd1080};
    run_req(1'b0, tv);
    chk(got_done && got_n == 0, "R1 no words", got_n, 0);
    chk(bypass_o && !err_o, "R1 bypass flag", {bypass_o, err_o}, 2'b10);

    // R11 zero source
    tv = '{1'b0, 1'b0, 1'b0, 2'd0, 16'd0, 16'd480, 16'd1920, 16'd1080};
    run_req(1'b0, tv);
    chk(got_done && got_n == 0, "R11 no words", got_n, 0);
    chk(err_o && !bypass_o, "R11 error flag", {err_o, bypass_o}, 2'b10);
    tv = '{1'b1, 1'b1, 1'b0, 2'd0, 16'd640, 16'd0, 16'd1920, 16'd1080};
    run_req(1'b0, tv);
    chk(got_n == 0 && err_o, "R11 zero height", {got_n[3:0], err_o}, 5'b00001);

    // R10 disable
    run_req(1'b1, tv);
    chk(got_done && got_n == 2, "R10 word count", got_n, 2);
    chk(got_k[0] == 2'd0 && got_w[0] == '0, "R10 ctrl zero", got_w[0], 0);
    chk(got_k[1] == 2'd2 && got_w[1] == '0, "R10 size zero", got_w[1], 0);
    chk(!err_o && !bypass_o, "R10 flags cleared", {err_o, bypass_o}, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule